// File: doc/BRIEF.md
# I2S Master Clock Generator

This block acts as the clock master of a stereo I2S link. From a single fixed reference clock (12 MHz in the intended system) it produces the serial bit clock and the left/right frame clock. It also produces a one-cycle frame-start strobe, which the serial data shifters elsewhere on the chip use to align their words. Playback and capture share the same frame clock, so both directions always run at one rate, one channel count and one sample width.

Software writes a 16-bit configuration word into a staging register. The word carries the master enable, the frame length stored as bits-minus-one, and a sparse 3-bit frame-rate code. The word has no effect until an application-reset pulse arrives. The pulse copies it into the running generator and restarts the clocks from a clean frame boundary, so a live stream never changes rate in the middle of a frame.

The reference is not an integer multiple of every bit rate; 12 MHz divided by 32 × 48 kHz, for example, leaves a fraction. For that reason the bit-clock edges come from a fractional phase accumulator. The average rate is exact, and each edge lands on the nearest reference cycle.

Top module: `i2s_master_clkgen`

## Requirements
- R1: The configuration word is decoded as follows. Bit 15 is the master enable. Bits 14:4 hold the frame length N minus one. Bits 2:0 hold the rate code, where 1 selects 8 kHz, 2 selects 16 kHz and 6 selects 48 kHz. Bit 3 is ignored.
- R2: A configuration write changes nothing at the outputs until the next app_reset pulse. The running clocks keep their previous timing until then.
- R3: While rst_n is low, and after rst_n rises until a valid configuration is applied, bclk, lrclk, frame_start and config_error are all low.
- R4: The interval between consecutive frame_start pulses is within one reference cycle of REF_HZ / fs.
- R5: Every bclk high or low phase lasts floor(REF_HZ/(2·fs·N)) or ceil(REF_HZ/(2·fs·N)) reference cycles.
- R6: Exactly N rising edges of bclk occur between consecutive frame_start pulses.
- R7: lrclk is low for the left channel and high for the right channel. It changes only when bclk falls, and it changes one bit clock before the first bit of each channel. Within a frame it is high at the rising edges of slots N/2-1 through N-2 and low at all others.
- R8: frame_start is a one-cycle pulse. It appears on the bclk falling edge that begins slot 0, and lrclk is low when it appears.
- R9: config_error rises, and bclk, lrclk and frame_start stay low, when the applied word has the enable set and any of the following holds: the rate code is not 1, 2 or 6; the length field is even (which gives an odd N); or 2·fs·N is not below REF_HZ.
- R10: When the applied word has the enable clear, config_error is low and the clocks stay idle low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fixed reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the staging register |
| cfg_wdata | input | 16 | Configuration word to stage |
| app_reset | input | 1 | Application-reset pulse that applies the staged word |
| bclk | output | 1 | Serial bit clock |
| lrclk | output | 1 | Frame (word-select) clock, low for left |
| frame_start | output | 1 | One-cycle strobe at the start of each frame |
| config_error | output | 1 | The applied configuration cannot be generated |

## Verification
The bench checks the following visible symptoms.

| Internal fault | What appears at the ports | When |
|---|---|---|
| Wrong accumulator increment or modulus | frame_start interval wrong | Within the first frame, a few hundred to 1500 reference cycles |
| Slot counter off by one | Wrong count of bclk rises per frame, or lrclk high at the wrong slots | At the first frame boundary |
| Staging register that leaks into the active copy | Interval moves before any app_reset | Within the first frame after the write |
| Faulty validity decode | config_error set wrongly, or bclk toggling while config_error is high | A few cycles after the pulse |

// File: rtl/i2sclk_pkg.sv
package i2sclk_pkg;

  // Configuration word layout: software writes it, so the bit positions are fixed.
  typedef struct packed {
    logic        master;   // [15]
    logic [10:0] len_m1;   // [14:4] frame bits minus one
    logic        unused;   // [3]
    logic [2:0]  rate;     // [2:0] sparse frame-rate code
  } cfg_t;

  function automatic logic [31:0] rate_hz(input logic [2:0] code);
    case (code)
      3'd1:    return 32'd8000;
      3'd2:    return 32'd16000;
      3'd6:    return 32'd48000;
      default: return 32'd0;
    endcase
  endfunction

  // Number of bclk edges (both polarities) per second.
  function automatic logic [31:0] edge_rate(input cfg_t c);
    logic [31:0] nbits;
    nbits = {21'd0, c.len_m1} + 32'd1;
    return (rate_hz(c.rate) * nbits) << 1;
  endfunction

  function automatic logic cfg_ok(input cfg_t c, input logic [31:0] ref_hz);
    return (rate_hz(c.rate) != 32'd0) && c.len_m1[0] && (edge_rate(c) < ref_hz);
  endfunction

  // The frame clock reports which channel the slot *after* this one belongs to.
  function automatic logic next_is_right(input logic [10:0] slot, input logic [10:0] len_m1);
    logic [10:0] nxt;
    logic [11:0] half;
    nxt  = (slot == len_m1) ? 11'd0 : slot + 11'd1;
    half = ({1'b0, len_m1} + 12'd1) >> 1;
    return {1'b0, nxt} >= half;
  endfunction

endpackage

// File: rtl/i2sclk_cfg_hold.sv
module i2sclk_cfg_hold
  import i2sclk_pkg::*;
#(
  parameter int unsigned REF_HZ = 12_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  input  logic        apply,
  output cfg_t        active,
  output logic        run,
  output logic        cfg_err,
  output logic        restart
);
  cfg_t staged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged  <= '0;
      active  <= '0;
      run     <= 1'b0;
      cfg_err <= 1'b0;
      restart <= 1'b0;
    end else begin
      restart <= apply;
      if (wr_en) staged <= cfg_t'(wdata);
      if (apply) begin
        active  <= staged;
        run     <= staged.master && cfg_ok(staged, 32'(REF_HZ));
        cfg_err <= staged.master && !cfg_ok(staged, 32'(REF_HZ));
      end
    end
  end
endmodule

// File: rtl/i2sclk_phase.sv
module i2sclk_phase #(
  parameter int unsigned REF_HZ = 12_000_000,
  parameter int unsigned ACC_W  = $clog2(REF_HZ) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [ACC_W-1:0] inc,
  output logic             tick
);
  localparam logic [ACC_W:0] MODULUS = (ACC_W+1)'(REF_HZ);

  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc} + {1'b0, inc};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      tick <= 1'b0;
    end else if (clear || !run) begin
      acc  <= '0;
      tick <= 1'b0;
    end else if (sum >= MODULUS) begin
      acc  <= ACC_W'(sum - MODULUS);
      tick <= 1'b1;
    end else begin
      acc  <= ACC_W'(sum);
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/i2sclk_frame_seq.sv
module i2sclk_frame_seq
  import i2sclk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        tick,
  input  logic [10:0] len_m1,
  output logic        bclk,
  output logic        lrclk,
  output logic        frame_start
);
  logic [10:0] slot;
  logic [10:0] slot_nxt;

  assign slot_nxt = (slot == len_m1) ? 11'd0 : slot + 11'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot        <= '0;
      bclk        <= 1'b0;
      lrclk       <= 1'b0;
      frame_start <= 1'b0;
    end else if (clear) begin
      slot        <= len_m1;   // the first falling edge then opens slot 0
      bclk        <= 1'b0;
      lrclk       <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      frame_start <= 1'b0;
      if (tick) begin
        bclk <= !bclk;
        if (bclk) begin
          slot        <= slot_nxt;
          lrclk       <= next_is_right(slot_nxt, len_m1);
          frame_start <= (slot_nxt == 11'd0);
        end
      end
    end
  end
endmodule

// File: rtl/i2s_master_clkgen.sv
module i2s_master_clkgen
  import i2sclk_pkg::*;
#(
  parameter int unsigned REF_HZ = 12_000_000
) (
  input  logic        clk_ref,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [15:0] cfg_wdata,
  input  logic        app_reset,
  output logic        bclk,
  output logic        lrclk,
  output logic        frame_start,
  output logic        config_error
);
  localparam int unsigned ACC_W = $clog2(REF_HZ) + 1;

  cfg_t             active;
  logic             run;
  logic             restart;
  logic             tick;
  logic [ACC_W-1:0] inc;

  assign inc = ACC_W'(edge_rate(active));

  i2sclk_cfg_hold #(.REF_HZ(REF_HZ)) u_cfg (
    .clk(clk_ref), .rst_n(rst_n), .wr_en(cfg_wr), .wdata(cfg_wdata),
    .apply(app_reset), .active(active), .run(run), .cfg_err(config_error),
    .restart(restart)
  );

  i2sclk_phase #(.REF_HZ(REF_HZ), .ACC_W(ACC_W)) u_phase (
    .clk(clk_ref), .rst_n(rst_n), .clear(restart), .run(run), .inc(inc), .tick(tick)
  );

  i2sclk_frame_seq u_seq (
    .clk(clk_ref), .rst_n(rst_n), .clear(restart), .tick(tick),
    .len_m1(active.len_m1), .bclk(bclk), .lrclk(lrclk), .frame_start(frame_start)
  );
endmodule

// File: rtl/i2sclk_checker.sv
module i2sclk_checker (
  input logic clk,
  input logic rst_n,
  input logic bclk,
  input logic lrclk,
  input logic frame_start,
  input logic config_error,
  input logic restart,
  input logic run,
  input logic tick
);
  // R7: outside a restart, the frame clock moves only with a falling bit clock
  p_lr_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(lrclk) && !$past(restart)) |-> $fell(bclk));

  // R8: the strobe sits on a falling bit clock with the left channel selected
  p_fs_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> ($fell(bclk) && !lrclk));

  // R8: the strobe lasts one cycle
  p_fs_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  // R9: a rejected configuration keeps every clock quiet once restarted
  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (config_error && !restart) |-> (!bclk && !lrclk && !frame_start));

  // R10: no edge request while the generator is stopped
  p_idle_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> !tick);
endmodule

bind i2s_master_clkgen i2sclk_checker u_chk (
  .clk(clk_ref), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk),
  .frame_start(frame_start), .config_error(config_error),
  .restart(restart), .run(run), .tick(tick)
);

// File: tb/i2s_master_clkgen_tb_top.sv
module i2s_master_clkgen_tb_top;
  localparam int REF = 12_000_000;
  localparam int NV  = 10;

  // Vector table: config word, expected frame period (ref cycles), N, expected error.
  // Word = enable<<15 | (N-1)<<4 | rate code (R1).
  localparam logic [15:0] V_CFG [NV] = '{
    16'h81F6, 16'h81F2, 16'h81F1, 16'h80F6, 16'h83F2,
    16'h81F3, 16'h81F0, 16'h81E6, 16'hFFF6, 16'h01F6 };
  localparam int V_PER [NV] = '{250, 750, 1500, 250, 750, 0, 0, 0, 0, 0};
  localparam int V_N   [NV] = '{32, 32, 32, 16, 64, 0, 0, 0, 0, 0};
  localparam bit V_ERR [NV] = '{0, 0, 0, 0, 0, 1, 1, 1, 1, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic app_reset = 1'b0;
  logic bclk, lrclk, frame_start, config_error;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2s_master_clkgen #(.REF_HZ(REF)) dut_i (
    .clk_ref(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .app_reset(app_reset), .bclk(bclk), .lrclk(lrclk),
    .frame_start(frame_start), .config_error(config_error)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [15:0] w);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic pulse_apply();
    @(negedge clk); app_reset = 1'b1;
    @(negedge clk); app_reset = 1'b0;
  endtask

  // Counts cycles in which any output shows activity.
  task automatic quiet(input int cycles, input string req);
    int busy = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (bclk || lrclk || frame_start) busy++;
    end
    chk(busy == 0, req, "active cycles while idle", busy, 0);
  endtask

  // Measures two frames; returns the last frame interval.
  task automatic measure(input int per, input int n, output int last_per);
    int t = 0;
    int lo, hi;
    lo = per / (2 * n);
    hi = (per % (2 * n) != 0) ? lo + 1 : lo;
    last_per = -1;
    while (!frame_start && t < 4 * per + 200) begin @(negedge clk); t++; end
    chk(frame_start, "R8", "frame_start seen", int'(frame_start), 1);
    if (!frame_start) return;
    for (int f = 0; f < 2; f++) begin
      int cyc = 0, rises = 0, highs = 0, hc = 0, hmin = 1000000, hmax = 0;
      bit pb = bclk, last_lr = 1'b1, lr_half = 1'b0;
      do begin
        @(negedge clk); cyc++; hc++;
        if (bclk != pb) begin
          if (hc < hmin) hmin = hc;
          if (hc > hmax) hmax = hc;
          hc = 0;
          if (bclk) begin
            if (rises == n / 2 - 1) lr_half = lrclk;
            rises++;
            highs += int'(lrclk);
            last_lr = lrclk;
          end
          pb = bclk;
        end
      end while (!frame_start && cyc < 4 * per + 200);
      last_per = cyc;
      chk(cyc >= per - 1 && cyc <= per + 1, "R4", "frame interval", cyc, per);
      chk(rises == n, "R6", "bclk rises per frame", rises, n);
      chk(highs == n / 2, "R7", "right-channel slots", highs, n / 2);
      chk(last_lr == 1'b0, "R7", "lrclk at last slot", int'(last_lr), 0);
      chk(lr_half == 1'b1, "R7", "lrclk at last left slot", int'(lr_half), 1);
      chk(hmin >= lo, "R5", "shortest half period", hmin, lo);
      chk(hmax <= hi, "R5", "longest half period", hmax, hi);
      chk(!lrclk, "R8", "lrclk at frame_start", int'(lrclk), 0);
    end
  endtask

  initial begin
    int p;
    // R3: reset state
    repeat (5) @(negedge clk);
    chk(!bclk && !lrclk && !frame_start && !config_error, "R3", "outputs in reset",
        {bclk, lrclk, frame_start, config_error}, 0);
    rst_n = 1'b1;
    quiet(50, "R3");
    chk(!config_error, "R3", "config_error after reset", int'(config_error), 0);

    // Vector walk (R1 decode, R9 rejects, R10 disable)
    for (int v = 0; v < NV; v++) begin
      write_cfg(V_CFG[v]);
      pulse_apply();
      repeat (3) @(negedge clk);
      chk(config_error == V_ERR[v], V_ERR[v] ? "R9" : "R1", "config_error",
          int'(config_error), int'(V_ERR[v]));
      if (V_PER[v] != 0) measure(V_PER[v], V_N[v], p);
      else quiet(2000, V_ERR[v] ? "R9" : "R10");
    end

    // R2: staged word has no effect before the app_reset pulse
    write_cfg(16'h81F6);
    pulse_apply();
    measure(250, 32, p);
    write_cfg(16'h81F1);
    measure(250, 32, p);
    chk(p >= 249 && p <= 251, "R2", "rate before apply", p, 250);
    pulse_apply();
    measure(1500, 32, p);
    chk(p >= 1499 && p <= 1501, "R2", "rate after apply", p, 1500);

    // R9: error clears when a valid word is applied
    write_cfg(16'h81F3);
    pulse_apply();
    repeat (3) @(negedge clk);
    chk(config_error, "R9", "error on bad code", int'(config_error), 1);
    write_cfg(16'h81F2);
    repeat (200) @(negedge clk);
    chk(config_error, "R2", "error held until apply", int'(config_error), 1);
    pulse_apply();
    repeat (3) @(negedge clk);
    chk(!config_error, "R9", "error cleared", int'(config_error), 0);
    measure(750, 32, p);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule